// File: doc/BRIEF.md
# Flow-through late-write synchronous SRAM

This block is a small-depth synchronous SRAM with flow-through reads and late writes. Every control input is registered on the rising clock edge. A read command returns its word on the shared data bus during the cycle that follows the capturing edge, with no output register in the path. A write command takes its data and byte strobes one enabled edge after its address. Because of this offset, read and write commands can alternate on consecutive cycles and never need an idle turnaround cycle.

A load/advance input chooses between two actions on each edge. It can start a new access at an external address, or it can step a 2-bit burst offset in linear or interleaved order. A step keeps the operation type of the access in progress. Three chip enables of mixed polarity allow depth expansion, and a clock enable freezes the whole block. Output enable and sleep act on the bus drivers without waiting for a clock edge. The word is 36 bits wide, made of four 9-bit lanes, and the storage array is a plain register file.

Top module: `ftlw_sram`

## Requirements
- R1: State changes only on a rising edge where `cke_n` is 0 and `sleep` is 0. When `cke_n` is 1 the edge is ignored. The burst address, the operation type and any late write still waiting for its data all keep their values.
- R2: A load cycle (`adv`=0) selects the chip only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. In that case `we_n`=1 gives a read and `we_n`=0 gives a write. Any other chip-enable combination on a load gives a deselect: `dq_oe` stays 0 in the following cycle and nothing is written.
- R3: Reads are flow-through. After the edge that captures a read, `dq_oe` is 1 and `dq` holds the addressed word for that same cycle. A burst delivers one word per cycle after the first, which gives a 2-1-1-1 pattern.
- R4: The write is late. The data on `dq` and the strobes `bw_n` are taken on the next enabled edge after the write address. `bw_n[i]`=0 writes lane i, which is `dq[9i+8:9i]`. A lane whose strobe is 1 keeps its old contents.
- R5: Reads and writes may alternate on every cycle with no idle cycle. A read that directly follows a write to the same address returns the newly written bytes. `dq_oe` is 0 while a write is in progress.
- R6: An advance cycle (`adv`=1) steps the 2-bit burst offset and keeps the operation type, including deselect. On an advance the chip enables, `we_n` and `addr` are ignored, and the address bits above the two LSBs do not change.
- R7: With `order_sel`=0 the offset after n advances is (start+n) mod 4. With `order_sel`=1 it is start XOR n. Here start is `addr[1:0]` at the load, and n counts modulo 4.
- R8: `oe_n`=1 turns the drivers off at once, without waiting for a clock edge, and leaves the internal state unchanged. When `oe_n` returns to 0, the pending read word is driven again.
- R9: `sleep`=1 turns the drivers off at once and blocks every command. The array contents and the access state are kept. After `sleep` returns to 0, the access in progress before sleep resumes.
- R10: After reset no access is active and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all capture on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address; its two LSBs seed the burst offset on a load |
| adv | input | 1 | 0 loads a new access, 1 advances the burst |
| we_n | input | 1 | Active-low write select on a load |
| bw_n | input | LANES | Active-low byte-lane strobes, sampled with the late write data |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| cke_n | input | 1 | Active-low clock enable |
| oe_n | input | 1 | Active-low output enable, acts without a clock edge |
| sleep | input | 1 | Active-high sleep, acts without a clock edge |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq | inout | LANES*LANE_W | Bidirectional data bus |
| dq_oe | output | 1 | High while the block drives `dq` |

## Verification
The hardest case to reach from the ports is a late write whose data edge is delayed. If a clock-enable stall or a sleep period falls between the write address and its data, the bus may carry stray data at the edges in between, and only the later enabled edge may take it. The stimulus sets this up by holding `cke_n` or `sleep` high for one or more cycles after the write address, with junk on the bus during those cycles. It then reads both the target word and a neighbour. Burst-order faults are a second hard case, because they cancel out when a burst is written and read back in the same order. For that reason each burst-written location is also read back with its own load cycle at its absolute address.

// File: rtl/ftlw_pkg.sv
package ftlw_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Offset of the n-th beat of a burst that started at offset 'start'.
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] n,
                                              input logic       interleave);
    logic [1:0] res;
    if (interleave) res = start ^ n;
    else            res = start + n;
    return res;
  endfunction

  // Chip select decode of the three enables.
  function automatic logic chip_selected(input logic e_lo_a,
                                         input logic e_hi,
                                         input logic e_lo_b);
    return !e_lo_a && e_hi && !e_lo_b;
  endfunction

endpackage

// File: rtl/ftlw_burst.sv
module ftlw_burst import ftlw_pkg::*; #(
  parameter int ADDR_W = 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              load,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int BASE_W = ADDR_W - 2;

  logic [BASE_W-1:0] base_q;
  logic [1:0]        start_q;
  logic [1:0]        cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (cap_en) begin
      if (load) begin
        base_q  <= ext_addr[ADDR_W-1:2];
        start_q <= ext_addr[1:0];
        cnt_q   <= 2'd0;
      end else begin
        cnt_q   <= cnt_q + 2'd1;
      end
    end
  end

  assign cur_addr = {base_q, burst_offset(start_q, cnt_q, order_sel)};

  AST_STALL_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && $stable(order_sel)) |=> $stable(cur_addr)); // R1
  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && load) |=> cur_addr == $past(ext_addr)); // R6
  AST_ADV_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !load) |=> $stable(cur_addr[ADDR_W-1:2])); // R6
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !load && !order_sel) ##1 !order_sel |->
      cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1); // R7

endmodule

// File: rtl/ftlw_ctrl.sv
module ftlw_ctrl import ftlw_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic load,
  input  logic sel,
  input  logic we_n,
  output op_e  op_q,
  output logic wr_commit,
  output logic rd_active
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_IDLE;
    end else if (cap_en && load) begin
      if (!sel)      op_q <= OP_IDLE;
      else if (we_n) op_q <= OP_READ;
      else           op_q <= OP_WRITE;
    end
  end

  assign wr_commit = cap_en && (op_q == OP_WRITE);
  assign rd_active = (op_q == OP_READ);

  AST_STALL_HOLDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(op_q)); // R1
  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && load && !sel) |=> op_q == OP_IDLE); // R2
  AST_ADV_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !load) |=> op_q == $past(op_q)); // R6

endmodule

// File: rtl/ftlw_array.sv
module ftlw_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
)(
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [LANES-1:0]         lane_en,
  input  logic [LANES*LANE_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [LANES*LANE_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && lane_en[g]) bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
  end

endmodule

// File: rtl/ftlw_sram.sv
module ftlw_sram import ftlw_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    adv,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    cke_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic                    order_sel,
  inout  wire  [LANES*LANE_W-1:0] dq,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  // Named internal events, used by the assertions.
  logic              cap_en;
  logic              load;
  logic              chip_sel;
  logic [ADDR_W-1:0] cur_addr;
  op_e               op_q;
  logic              wr_commit;
  logic              rd_active;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] bus_in;

  assign cap_en   = !cke_n && !sleep;
  assign load     = !adv;
  assign chip_sel = chip_selected(ce1_n, ce2, ce3_n);
  assign bus_in   = dq;

  ftlw_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .load      (load),
    .order_sel (order_sel),
    .ext_addr  (addr),
    .cur_addr  (cur_addr)
  );

  ftlw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .load      (load),
    .sel       (chip_sel),
    .we_n      (we_n),
    .op_q      (op_q),
    .wr_commit (wr_commit),
    .rd_active (rd_active)
  );

  // The late write lands at the address held since the previous edge.
  ftlw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .wr_en   (wr_commit),
    .wr_addr (cur_addr),
    .lane_en (~bw_n),
    .wr_data (bus_in),
    .rd_addr (cur_addr),
    .rd_data (rd_word)
  );

  assign dq_oe = rd_active && !oe_n && !sleep;
  assign dq    = dq_oe ? rd_word : {DATA_W{1'bz}};

  AST_DRIVERS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || sleep) |-> !dq_oe); // R8
  AST_SLEEP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(cur_addr) || $changed(order_sel)) && $stable(op_q)); // R9
  AST_READ_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && load && chip_sel && we_n) ##1 (!oe_n && !sleep) |-> dq_oe); // R3
  AST_WRITE_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_WRITE) |-> !dq_oe); // R5

endmodule

// File: tb/ftlw_sram_bench.sv
module ftlw_sram_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic        adv, we_n, ce1_n, ce2, ce3_n, cke_n, oe_n, sleep, order_sel;
  logic [3:0]  bw_n;
  wire  [35:0] dq;
  logic        dq_oe;
  logic        tb_drv;
  logic [35:0] tb_dq;

  logic [35:0] model [64];
  int n_chk = 0;
  int n_bad = 0;

  assign dq = tb_drv ? tb_dq : {36{1'bz}};

  always #10 clk = ~clk;

  ftlw_sram u_ftlw_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adv(adv), .we_n(we_n), .bw_n(bw_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .cke_n(cke_n), .oe_n(oe_n),
    .sleep(sleep), .order_sel(order_sel), .dq(dq), .dq_oe(dq_oe)
  );

  task automatic check(input logic ok, input string req,
                       input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_word(input string req, input logic [35:0] exp);
    check(dq_oe === 1'b1 && dq === exp, req, dq, exp);
  endtask

  task automatic expect_float(input string req);
    check(dq_oe === 1'b0, req, {35'd0, dq_oe}, 36'd0);
  endtask

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                        input logic [3:0] bw);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (!bw[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  function automatic logic [5:0] beat_addr(input logic [5:0] a, input int n, input logic il);
    int s = int'(a[1:0]);
    int o = il ? (s ^ n) : ((s + n) % 4);
    return {a[5:2], 2'(o)};
  endfunction

  // One cycle: inputs set after a falling edge, outputs seen at the next one.
  task automatic issue(input logic adv_i, input logic we_i, input logic [5:0] a,
                       input logic drv, input logic [35:0] wd, input logic [3:0] bw);
    adv = adv_i; we_n = we_i; addr = a; tb_drv = drv; tb_dq = wd; bw_n = bw;
    @(posedge clk);
    #1 tb_drv = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [5:0] a, input logic [35:0] d, input logic [3:0] bw);
    issue(1'b0, 1'b0, a, 1'b0, '0, 4'hF);
    ce1_n = 1'b1;
    issue(1'b0, 1'b1, 6'd0, 1'b1, d, bw);
    ce1_n = 1'b0;
    model[a] = merge(model[a], d, bw);
  endtask

  task automatic read_word(input string req, input logic [5:0] a);
    issue(1'b0, 1'b1, a, 1'b0, '0, 4'hF);
    expect_word(req, model[a]);
  endtask

  task automatic t_reset();
    expect_float("R10 drivers off after reset");
  endtask

  task automatic t_alternate();
    write_word(6'd1, 36'h0_1111_2222, 4'h0);
    issue(1'b0, 1'b0, 6'd5, 1'b0, '0, 4'hF);
    issue(1'b0, 1'b1, 6'd5, 1'b1, 36'hA_BCDE_F012, 4'h0);
    model[5] = 36'hA_BCDE_F012;
    expect_word("R5 read right after write", model[5]);
    issue(1'b0, 1'b0, 6'd9, 1'b0, '0, 4'hF);
    expect_float("R5 bus quiet during write");
    issue(1'b0, 1'b1, 6'd9, 1'b1, 36'h5_5555_AAAA, 4'h0);
    model[9] = 36'h5_5555_AAAA;
    expect_word("R5 second write-read pair", model[9]);
    issue(1'b0, 1'b1, 6'd1, 1'b0, '0, 4'hF);
    expect_word("R3 flow-through read", model[1]);
  endtask

  task automatic t_lanes();
    write_word(6'd12, 36'hF_FFFF_FFFF, 4'h0);
    write_word(6'd12, 36'h1_2345_6789, 4'b0101);
    read_word("R4 lanes 1 and 3 written, 0 and 2 kept", 6'd12);
    write_word(6'd12, 36'h0_0000_0000, 4'b1110);
    read_word("R4 only lane 0 written", 6'd12);
  endtask

  task automatic t_burst(input logic il, input logic [5:0] a, input logic [35:0] d);
    order_sel = il;
    issue(1'b0, 1'b0, a, 1'b0, '0, 4'hF);
    ce1_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      issue(1'b1, 1'b1, 6'h3F, 1'b1, d + 36'(k), 4'h0);
      model[beat_addr(a, k, il)] = d + 36'(k);
    end
    issue(1'b0, 1'b1, 6'd0, 1'b1, d + 36'd3, 4'h0);
    model[beat_addr(a, 3, il)] = d + 36'd3;
    ce1_n = 1'b0;
    for (int k = 0; k < 4; k++)
      read_word(il ? "R7 interleaved beat placement" : "R7 linear beat placement with wrap",
                {a[5:2], 2'(k)});
    issue(1'b0, 1'b1, a, 1'b0, '0, 4'hF);
    expect_word("R3 burst first beat", model[beat_addr(a, 0, il)]);
    for (int k = 1; k < 4; k++) begin
      issue(1'b1, 1'b0, 6'h00, 1'b0, '0, 4'hF);
      expect_word("R6 burst advance one beat per cycle", model[beat_addr(a, k, il)]);
    end
    order_sel = 1'b0;
  endtask

  task automatic t_clock_enable();
    write_word(6'd20, 36'h2_0202_0202, 4'h0);
    write_word(6'd21, 36'h2_1212_1212, 4'h0);
    write_word(6'd23, 36'h2_3333_3333, 4'h0);
    issue(1'b0, 1'b1, 6'd20, 1'b0, '0, 4'hF);
    cke_n = 1'b1;
    issue(1'b0, 1'b1, 6'd21, 1'b0, '0, 4'hF);
    issue(1'b0, 1'b0, 6'd23, 1'b0, '0, 4'hF);
    expect_word("R1 stalled edges ignored", model[20]);
    cke_n = 1'b0;
    issue(1'b1, 1'b1, 6'd0, 1'b0, '0, 4'hF);
    expect_word("R1 burst resumes after stall", model[21]);
    issue(1'b0, 1'b0, 6'd22, 1'b0, '0, 4'hF);
    cke_n = 1'b1;
    issue(1'b0, 1'b1, 6'd23, 1'b1, 36'hD_EADD_EADD, 4'h0);
    cke_n = 1'b0;
    ce1_n = 1'b1;
    issue(1'b0, 1'b1, 6'd0, 1'b1, 36'h7_7777_0000, 4'h0);
    ce1_n = 1'b0;
    model[22] = 36'h7_7777_0000;
    read_word("R1 late write held over stall", 6'd22);
    read_word("R1 stalled command did not write", 6'd23);
  endtask

  task automatic t_deselect();
    ce2 = 1'b0;
    issue(1'b0, 1'b1, 6'd20, 1'b0, '0, 4'hF);
    ce2 = 1'b1;
    expect_float("R2 ce2 low deselects");
    issue(1'b1, 1'b1, 6'd20, 1'b0, '0, 4'hF);
    expect_float("R6 advance keeps deselect");
    ce3_n = 1'b1;
    issue(1'b0, 1'b0, 6'd20, 1'b0, '0, 4'hF);
    ce3_n = 1'b0;
    expect_float("R2 ce3_n high deselects");
    ce1_n = 1'b1;
    issue(1'b0, 1'b1, 6'd0, 1'b1, 36'hB_ADBA_DBAD, 4'h0);
    ce1_n = 1'b0;
    read_word("R2 deselected write left word intact", 6'd20);
  endtask

  task automatic t_output_enable();
    issue(1'b0, 1'b1, 6'd21, 1'b0, '0, 4'hF);
    #2 oe_n = 1'b1;
    #1 expect_float("R8 oe_n high floats bus at once");
    oe_n = 1'b0;
    #1 expect_word("R8 word back after oe_n low", model[21]);
  endtask

  task automatic t_sleep();
    issue(1'b0, 1'b1, 6'd20, 1'b0, '0, 4'hF);
    #2 sleep = 1'b1;
    #1 expect_float("R9 sleep floats bus at once");
    @(negedge clk);
    issue(1'b0, 1'b0, 6'd20, 1'b0, '0, 4'hF);
    issue(1'b0, 1'b1, 6'd21, 1'b1, 36'hC_C0FF_EE00, 4'h0);
    expect_float("R9 bus stays off while asleep");
    sleep = 1'b0;
    #1 expect_word("R9 read resumes after wake", model[20]);
    read_word("R9 contents kept through sleep", 6'd20);
    read_word("R9 sleeping write ignored", 6'd21);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 36'd1, 36'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    rst_n = 1'b0; addr = '0; adv = 1'b0; we_n = 1'b1; bw_n = 4'hF;
    ce1_n = 1'b1; ce2 = 1'b1; ce3_n = 1'b0; cke_n = 1'b0; oe_n = 1'b0;
    sleep = 1'b0; order_sel = 1'b0; tb_drv = 1'b0; tb_dq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    ce1_n = 1'b0;
    t_alternate();
    t_lanes();
    t_burst(1'b0, 6'h33, 36'h0_0000_1000);
    t_burst(1'b1, 6'h2A, 36'h0_0000_2000);
    t_burst(1'b1, 6'h3D, 36'h0_0000_3000);
    t_clock_enable();
    t_deselect();
    t_output_enable();
    t_sleep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule